// File: doc/BRIEF.md
# Filtered Stride Prefetch Engine

This engine watches a stream of cache access requests and learns a constant stride from the full byte address. The low offset bits are kept during training, so a stride that is not a multiple of the line size still looks constant. Each request first passes through a configurable eligibility filter. The filter can drop uncacheable requests, instruction fetches, cache hits or writes. Only requests that pass the filter update the stride state or start prefetch generation.

When a request confirms the stride it has learned, the engine computes up to `DEGREE` targets in the same cycle. Each target is the request address plus a multiple of the stride, rounded down to its cache-block address. The engine removes duplicate blocks, can stop at a page boundary, and pushes the surviving targets into a small queue.

Prefetches leave the queue through a valid/ready port. Each carries a block address and, when tagging is enabled, the program counter of the triggering request. A lower-level prefetcher can train on that tag. When the queue overflows, the oldest entries are discarded and a drop counter records how many were lost.

Top module: `stride_prefetch_engine`

## Requirements
- R1: The stride is the difference between the full byte addresses of two consecutive eligible requests, taken modulo 2^32 and treated as signed. For example, requests at 0x1000, 0x1030 and 0x1060 give a constant stride of 48 over 64-byte lines.
- R2: A request with `req_uncacheable` high never updates the stride state and never produces prefetches.
- R3: With `cfg_data_only` high, a request with `req_is_fetch` high is ignored.
- R4: With `cfg_miss_only` high, a request with `req_hit` high is ignored.
- R5: With `cfg_read_only` high, a request with `req_is_read` low is ignored.
- R6: A trigger at address A with stride S produces targets A + k·S for k = 1..DEGREE. Each target has its low log2(LINE_BYTES) bits cleared. Targets are queued in increasing k, and the first one is visible on `pf_addr` one clock edge after the triggering request.
- R7: When `cfg_tag_pc` and `req_pc_valid` are both high, each queued prefetch carries `req_pc` with `pf_pc_valid` high. Otherwise `pf_pc_valid` is low and `pf_pc` is zero.
- R8: If a push would take the queue above QDEPTH entries, the oldest entries are discarded to make room. `full_drop_count` rises by the number discarded and saturates.
- R9: With `cfg_page_stop` high, the first target whose page number (address divided by PAGE_BYTES) differs from the trigger's page ends generation for that trigger. With it low, targets may cross pages.
- R10: An eligible request triggers only when its stride is nonzero and equals the stride seen at the previous eligible request. A change of stride, including a sign change, restarts learning.
- R11: Within one trigger, a target whose block address equals that of an earlier queued target from the same trigger is not queued.
- R12: After reset the queue is empty and `full_drop_count` is zero. While `pf_valid` is high and `pf_ready` is low, with no new push, the head entry is held unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Access request present this cycle |
| req_addr | input | 32 | Byte address of the access |
| req_pc | input | 32 | Program counter of the access |
| req_pc_valid | input | 1 | `req_pc` is meaningful |
| req_is_read | input | 1 | Access is a read |
| req_is_fetch | input | 1 | Access is an instruction fetch |
| req_uncacheable | input | 1 | Access is uncacheable |
| req_hit | input | 1 | Access hit in the cache |
| cfg_data_only | input | 1 | Ignore instruction fetches |
| cfg_miss_only | input | 1 | Ignore cache hits |
| cfg_read_only | input | 1 | Ignore non-read accesses |
| cfg_tag_pc | input | 1 | Attach the triggering PC to prefetches |
| cfg_page_stop | input | 1 | Stop generation at a page boundary |
| pf_valid | output | 1 | A prefetch is waiting at the queue head |
| pf_ready | input | 1 | Consumer takes the head prefetch |
| pf_addr | output | 32 | Block address of the head prefetch |
| pf_pc | output | 32 | PC tag of the head prefetch |
| pf_pc_valid | output | 1 | `pf_pc` is meaningful |
| full_drop_count | output | 16 | Saturating count of entries dropped on overflow |

## Verification
A triggering request sampled at one edge writes its targets into the queue at that same edge, so the head target appears on `pf_addr` exactly one edge later. Each later target appears one edge after the previous pop. The bench drives every request at a falling edge and reads the queue at the next falling edge, right after the single register stage. It then pops one entry per cycle while recording each one, so a missing, extra or late target shows up as a wrong count or order. For overflow, the bench holds `pf_ready` low across three triggers and reads the drop counter and the surviving entries at the falling edge after the last push.

// File: rtl/spe_pkg.sv
package spe_pkg;

    localparam int ADDR_W = 32;
    localparam int PC_W   = 32;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [PC_W-1:0]   pc_t;

    // One queued prefetch.
    typedef struct packed {
        addr_t blk;
        pc_t   pc;
        logic  pcv;
    } pf_entry_t;

    // Single stride-learning entry.
    typedef struct packed {
        addr_t      last_addr;
        addr_t      last_stride;
        logic [1:0] conf;
        logic       seen;
    } stride_ent_t;

    // Clear the low lsb bits of a byte address.
    function automatic addr_t blk_align(addr_t a, int lsb);
        return a & ~((addr_t'(1) << lsb) - addr_t'(1));
    endfunction

endpackage

// File: rtl/spe_req_filter.sv
module spe_req_filter (
    input  logic req_valid,
    input  logic is_read,
    input  logic is_fetch,
    input  logic uncacheable,
    input  logic hit,
    input  logic data_only,
    input  logic miss_only,
    input  logic read_only,
    output logic eligible
);
    logic blocked;

    always_comb begin
        blocked = uncacheable;
        if (data_only && is_fetch) blocked = 1'b1;
        if (miss_only && hit)      blocked = 1'b1;
        if (read_only && !is_read) blocked = 1'b1;
        eligible = req_valid && !blocked;
    end
endmodule

// File: rtl/spe_stride_tracker.sv
module spe_stride_tracker
    import spe_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  eligible,
    input  addr_t addr,
    output logic  trigger,
    output addr_t stride
);
    stride_ent_t ent_q;
    logic        match;
    logic [1:0]  conf_next;

    always_comb begin
        stride    = addr - ent_q.last_addr;
        match     = ent_q.seen && (stride != '0) && (stride == ent_q.last_stride);
        conf_next = match ? ((ent_q.conf == 2'b11) ? 2'b11 : ent_q.conf + 2'b01) : 2'b00;
        trigger   = eligible && (conf_next != 2'b00);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ent_q <= '0;
        end else if (eligible) begin
            ent_q.last_addr   <= addr;
            ent_q.last_stride <= ent_q.seen ? stride : '0;
            ent_q.conf        <= conf_next;
            ent_q.seen        <= 1'b1;
        end
    end
endmodule

// File: rtl/spe_target_gen.sv
module spe_target_gen
    import spe_pkg::*;
#(
    parameter int DEGREE   = 2,
    parameter int LINE_LSB = 6,
    parameter int PAGE_LSB = 12,
    parameter int SLOT_W   = 2
) (
    input  logic              trigger,
    input  addr_t             base,
    input  addr_t             stride,
    input  pc_t               pc,
    input  logic              pc_ok,
    input  logic              tag_pc,
    input  logic              page_stop,
    output logic [DEGREE-1:0] lane_keep,
    output pf_entry_t         lane_ent  [DEGREE],
    output logic [SLOT_W-1:0] lane_slot [DEGREE],
    output logic [SLOT_W-1:0] keep_n
);
    addr_t             tgt     [DEGREE];
    addr_t             blk     [DEGREE];
    logic [DEGREE-1:0] crossed;
    logic              tag_on;

    assign tag_on = tag_pc && pc_ok;

    for (genvar k = 0; k < DEGREE; k++) begin : g_lane
        assign tgt[k]     = base + stride * addr_t'(k + 1);
        assign blk[k]     = blk_align(tgt[k], LINE_LSB);
        assign crossed[k] = tgt[k][ADDR_W-1:PAGE_LSB] != base[ADDR_W-1:PAGE_LSB];
        assign lane_ent[k] = '{blk: blk[k], pc: (tag_on ? pc : '0), pcv: tag_on};
    end

    always_comb begin
        logic              alive;
        logic              dup;
        logic [DEGREE-1:0] kv;
        logic [SLOT_W-1:0] cnt;
        alive = trigger;
        kv    = '0;
        cnt   = '0;
        for (int k = 0; k < DEGREE; k++) begin
            if (page_stop && crossed[k]) alive = 1'b0;
            dup = 1'b0;
            for (int j = 0; j < DEGREE; j++) begin
                if (j < k && kv[j] && blk[j] == blk[k]) dup = 1'b1;
            end
            kv[k]        = alive && !dup;
            lane_slot[k] = cnt;
            cnt          = cnt + SLOT_W'(kv[k]);
        end
        lane_keep = kv;
        keep_n    = cnt;
    end
endmodule

// File: rtl/spe_drop_queue.sv
module spe_drop_queue
    import spe_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int DEGREE = 2,
    parameter int SLOT_W = 2,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DEGREE-1:0] push_keep,
    input  pf_entry_t         push_ent  [DEGREE],
    input  logic [SLOT_W-1:0] push_slot [DEGREE],
    input  logic [SLOT_W-1:0] push_n,
    input  logic              pop_ready,
    output logic              out_valid,
    output pf_entry_t         out_ent,
    output logic [CNT_W-1:0]  drop_count
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int OCC_W = $clog2(DEPTH + DEGREE + 1) + 1;

    pf_entry_t        mem [DEPTH];
    logic [PTR_W-1:0] head_q, tail_q;
    logic [OCC_W-1:0] occ_q, occ_mid, over;
    logic             pop;
    logic [CNT_W:0]   drop_sum;

    assign out_valid = occ_q != '0;
    assign out_ent   = mem[head_q];

    always_comb begin
        pop      = out_valid && pop_ready;
        occ_mid  = occ_q - OCC_W'(pop) + OCC_W'(push_n);
        over     = (occ_mid > OCC_W'(DEPTH)) ? occ_mid - OCC_W'(DEPTH) : '0;
        drop_sum = {1'b0, drop_count} + (CNT_W + 1)'(over);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            head_q     <= '0;
            tail_q     <= '0;
            occ_q      <= '0;
            drop_count <= '0;
        end else begin
            head_q     <= head_q + PTR_W'(pop) + PTR_W'(over);
            tail_q     <= tail_q + PTR_W'(push_n);
            occ_q      <= occ_mid - over;
            drop_count <= drop_sum[CNT_W] ? '1 : drop_sum[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        for (int k = 0; k < DEGREE; k++) begin
            if (push_keep[k]) mem[tail_q + PTR_W'(push_slot[k])] <= push_ent[k];
        end
    end
endmodule

// File: rtl/stride_prefetch_engine.sv
module stride_prefetch_engine
    import spe_pkg::*;
#(
    parameter int LINE_BYTES = 64,
    parameter int PAGE_BYTES = 4096,
    parameter int DEGREE     = 2,
    parameter int QDEPTH     = 4,
    parameter int CNT_W      = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [ADDR_W-1:0]  req_addr,
    input  logic [PC_W-1:0]    req_pc,
    input  logic               req_pc_valid,
    input  logic               req_is_read,
    input  logic               req_is_fetch,
    input  logic               req_uncacheable,
    input  logic               req_hit,
    input  logic               cfg_data_only,
    input  logic               cfg_miss_only,
    input  logic               cfg_read_only,
    input  logic               cfg_tag_pc,
    input  logic               cfg_page_stop,
    output logic               pf_valid,
    input  logic               pf_ready,
    output logic [ADDR_W-1:0]  pf_addr,
    output logic [PC_W-1:0]    pf_pc,
    output logic               pf_pc_valid,
    output logic [CNT_W-1:0]   full_drop_count
);
    localparam int LINE_LSB = $clog2(LINE_BYTES);
    localparam int PAGE_LSB = $clog2(PAGE_BYTES);
    localparam int SLOT_W   = $clog2(DEGREE + 1);

    logic              eligible, trigger;
    addr_t             stride;
    logic [DEGREE-1:0] lane_keep, lane_pcv;
    pf_entry_t         lane_ent  [DEGREE];
    logic [SLOT_W-1:0] lane_slot [DEGREE];
    logic [SLOT_W-1:0] push_n;
    pf_entry_t         head_ent;

    spe_req_filter u_filter (
        .req_valid  (req_valid),
        .is_read    (req_is_read),
        .is_fetch   (req_is_fetch),
        .uncacheable(req_uncacheable),
        .hit        (req_hit),
        .data_only  (cfg_data_only),
        .miss_only  (cfg_miss_only),
        .read_only  (cfg_read_only),
        .eligible   (eligible)
    );

    spe_stride_tracker u_tracker (
        .clk     (clk),
        .rst     (rst),
        .eligible(eligible),
        .addr    (req_addr),
        .trigger (trigger),
        .stride  (stride)
    );

    spe_target_gen #(
        .DEGREE  (DEGREE),
        .LINE_LSB(LINE_LSB),
        .PAGE_LSB(PAGE_LSB),
        .SLOT_W  (SLOT_W)
    ) u_gen (
        .trigger  (trigger),
        .base     (req_addr),
        .stride   (stride),
        .pc       (req_pc),
        .pc_ok    (req_pc_valid),
        .tag_pc   (cfg_tag_pc),
        .page_stop(cfg_page_stop),
        .lane_keep(lane_keep),
        .lane_ent (lane_ent),
        .lane_slot(lane_slot),
        .keep_n   (push_n)
    );

    for (genvar k = 0; k < DEGREE; k++) begin : g_pcv
        assign lane_pcv[k] = lane_ent[k].pcv;
    end

    spe_drop_queue #(
        .DEPTH (QDEPTH),
        .DEGREE(DEGREE),
        .SLOT_W(SLOT_W),
        .CNT_W (CNT_W)
    ) u_queue (
        .clk       (clk),
        .rst       (rst),
        .push_keep (lane_keep),
        .push_ent  (lane_ent),
        .push_slot (lane_slot),
        .push_n    (push_n),
        .pop_ready (pf_ready),
        .out_valid (pf_valid),
        .out_ent   (head_ent),
        .drop_count(full_drop_count)
    );

    assign pf_addr     = head_ent.blk;
    assign pf_pc       = head_ent.pc;
    assign pf_pc_valid = head_ent.pcv;
endmodule

// File: rtl/spe_checker.sv
module spe_checker #(
    parameter int LINE_LSB = 6,
    parameter int DEGREE   = 2,
    parameter int SLOT_W   = 2,
    parameter int CNT_W    = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_uncacheable,
    input logic              cfg_tag_pc,
    input logic              pf_valid,
    input logic              pf_ready,
    input logic [31:0]       pf_addr,
    input logic [CNT_W-1:0]  full_drop_count,
    input logic [SLOT_W-1:0] push_n,
    input logic [DEGREE-1:0] lane_pcv
);
    assert_blk_aligned_R6: assert property (@(posedge clk) disable iff (rst)
        pf_valid |-> pf_addr[LINE_LSB-1:0] == '0);

    assert_unc_no_push_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_uncacheable) |-> push_n == '0);

    assert_untagged_lanes_R7: assert property (@(posedge clk) disable iff (rst)
        !cfg_tag_pc |-> lane_pcv == '0);

    assert_drop_needs_push_R8: assert property (@(posedge clk) disable iff (rst)
        (push_n == '0) |=> $stable(full_drop_count));

    assert_head_held_R12: assert property (@(posedge clk) disable iff (rst)
        (pf_valid && !pf_ready && push_n == '0) |=> (pf_valid && $stable(pf_addr)));
endmodule

bind stride_prefetch_engine spe_checker #(
    .LINE_LSB(LINE_LSB),
    .DEGREE  (DEGREE),
    .SLOT_W  (SLOT_W),
    .CNT_W   (CNT_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .req_valid      (req_valid),
    .req_uncacheable(req_uncacheable),
    .cfg_tag_pc     (cfg_tag_pc),
    .pf_valid       (pf_valid),
    .pf_ready       (pf_ready),
    .pf_addr        (pf_addr),
    .full_drop_count(full_drop_count),
    .push_n         (push_n),
    .lane_pcv       (lane_pcv)
);

// File: tb/stride_prefetch_engine_tb.sv
`timescale 1ns/1ps
module stride_prefetch_engine_tb;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_pc = '0;
    logic        req_pc_valid = 1'b0, req_is_read = 1'b0, req_is_fetch = 1'b0;
    logic        req_uncacheable = 1'b0, req_hit = 1'b0;
    logic        cfg_data_only = 1'b0, cfg_miss_only = 1'b0, cfg_read_only = 1'b0;
    logic        cfg_tag_pc = 1'b0, cfg_page_stop = 1'b0;
    logic        pf_valid, pf_ready = 1'b0, pf_pc_valid;
    logic [31:0] pf_addr, pf_pc;
    logic [15:0] full_drop_count;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    stride_prefetch_engine u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_addr(req_addr),
        .req_pc(req_pc), .req_pc_valid(req_pc_valid), .req_is_read(req_is_read),
        .req_is_fetch(req_is_fetch), .req_uncacheable(req_uncacheable), .req_hit(req_hit),
        .cfg_data_only(cfg_data_only), .cfg_miss_only(cfg_miss_only),
        .cfg_read_only(cfg_read_only), .cfg_tag_pc(cfg_tag_pc), .cfg_page_stop(cfg_page_stop),
        .pf_valid(pf_valid), .pf_ready(pf_ready), .pf_addr(pf_addr), .pf_pc(pf_pc),
        .pf_pc_valid(pf_pc_valid), .full_drop_count(full_drop_count)
    );

    // rf = {pc_valid, read, fetch, uncacheable, hit}
    // cf = {data_only, miss_only, read_only, tag_pc, page_stop}
    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] pc;
        logic [4:0]  rf;
        logic [4:0]  cf;
        logic [1:0]  n;
        logic [31:0] a0;
        logic [31:0] a1;
        logic        epcv;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t VECS [NV] = '{
        '{32'h1000, 32'h0,    5'b01000, 5'b00000, 2'd0, 32'h0,    32'h0,    1'b0}, // R10 first access
        '{32'h1030, 32'h0,    5'b01000, 5'b00000, 2'd0, 32'h0,    32'h0,    1'b0}, // R10 stride seen once
        '{32'h1060, 32'h0,    5'b01000, 5'b00000, 2'd2, 32'h1080, 32'h10C0, 1'b0}, // R1 R6 48-byte stride
        '{32'h1090, 32'h0,    5'b01000, 5'b00000, 2'd1, 32'h10C0, 32'h0,    1'b0}, // R11 same-line targets
        '{32'h10C0, 32'h0,    5'b01010, 5'b00000, 2'd0, 32'h0,    32'h0,    1'b0}, // R2 uncacheable
        '{32'h10C0, 32'h0,    5'b01000, 5'b00000, 2'd2, 32'h10C0, 32'h1100, 1'b0}, // R2 state untouched
        '{32'h1F90, 32'h0,    5'b01000, 5'b00000, 2'd0, 32'h0,    32'h0,    1'b0}, // R10 new stride
        '{32'h1FC0, 32'h0,    5'b01000, 5'b00000, 2'd0, 32'h0,    32'h0,    1'b0}, // R10 changed stride
        '{32'h1FF0, 32'h0,    5'b01000, 5'b00000, 2'd2, 32'h2000, 32'h2040, 1'b0}, // R9 crossing allowed
        '{32'h2F90, 32'h0,    5'b01000, 5'b00000, 2'd0, 32'h0,    32'h0,    1'b0}, // R10
        '{32'h2FC0, 32'h0,    5'b01000, 5'b00000, 2'd0, 32'h0,    32'h0,    1'b0}, // R10
        '{32'h2FF0, 32'h0,    5'b01000, 5'b00001, 2'd0, 32'h0,    32'h0,    1'b0}, // R9 page stop
        '{32'h3020, 32'h0,    5'b01100, 5'b10000, 2'd0, 32'h0,    32'h0,    1'b0}, // R3 fetch ignored
        '{32'h3020, 32'h0,    5'b01100, 5'b00000, 2'd2, 32'h3040, 32'h3080, 1'b0}, // R3 fetch allowed
        '{32'h3050, 32'h0,    5'b01001, 5'b01000, 2'd0, 32'h0,    32'h0,    1'b0}, // R4 hit ignored
        '{32'h3050, 32'h0,    5'b01000, 5'b01000, 2'd1, 32'h3080, 32'h0,    1'b0}, // R4 miss trains
        '{32'h3080, 32'h0,    5'b00000, 5'b00100, 2'd0, 32'h0,    32'h0,    1'b0}, // R5 write ignored
        '{32'h3080, 32'h0,    5'b00000, 5'b00000, 2'd2, 32'h3080, 32'h30C0, 1'b0}, // R5 write allowed
        '{32'h30B0, 32'hABCD, 5'b11000, 5'b00010, 2'd2, 32'h30C0, 32'h3100, 1'b1}, // R7 tagged
        '{32'h30E0, 32'h0,    5'b01000, 5'b00010, 2'd2, 32'h3100, 32'h3140, 1'b0}, // R7 no valid pc
        '{32'h3110, 32'h1234, 5'b11000, 5'b00000, 2'd1, 32'h3140, 32'h0,    1'b0}, // R7 tag off
        '{32'h30E0, 32'h0,    5'b01000, 5'b00000, 2'd0, 32'h0,    32'h0,    1'b0}, // R10 sign change
        '{32'h30B0, 32'h0,    5'b01000, 5'b00000, 2'd2, 32'h3080, 32'h3040, 1'b0}  // R1 negative stride
    };

    logic [31:0] got_a   [8];
    logic [31:0] got_pc  [8];
    logic        got_pcv [8];
    int          got_n;

    task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", what, act, exp);
        end
    endtask

    task automatic send(input logic [31:0] a, input logic [31:0] pc, input logic [4:0] rf,
                        input logic [4:0] cf);
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        req_pc    = pc;
        {req_pc_valid, req_is_read, req_is_fetch, req_uncacheable, req_hit} = rf;
        {cfg_data_only, cfg_miss_only, cfg_read_only, cfg_tag_pc, cfg_page_stop} = cf;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Pop everything from the queue, recording each head entry.
    task automatic drain();
        got_n = 0;
        while (pf_valid && got_n < 8) begin
            got_a[got_n]   = pf_addr;
            got_pc[got_n]  = pf_pc;
            got_pcv[got_n] = pf_pc_valid;
            got_n++;
            pf_ready = 1'b1;
            @(negedge clk);
        end
        pf_ready = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R12 watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R12 reset state
        check("R12 pf_valid after reset", 32'(pf_valid), 32'd0);
        check("R12 drop count after reset", 32'(full_drop_count), 32'd0);

        for (int i = 0; i < NV; i++) begin
            send(VECS[i].addr, VECS[i].pc, VECS[i].rf, VECS[i].cf);
            drain();
            check($sformatf("vec%0d count (R6 R9 R10 R11)", i), 32'(got_n), 32'(VECS[i].n));
            if (VECS[i].n >= 1 && got_n >= 1) begin
                check($sformatf("vec%0d first addr R1 R6", i), got_a[0], VECS[i].a0);
                check($sformatf("vec%0d pcv R7", i), 32'(got_pcv[0]), 32'(VECS[i].epcv));
                check($sformatf("vec%0d pc R7", i), got_pc[0],
                      VECS[i].epcv ? VECS[i].pc : 32'h0);
            end
            if (VECS[i].n == 2 && got_n >= 2)
                check($sformatf("vec%0d second addr R6", i), got_a[1], VECS[i].a1);
        end

        // R12 hold and R8 drop-oldest; stride is -0x30 after last vector
        send(32'h3080, 32'h0, 5'b01000, 5'b00000);
        check("R12 head after push", pf_addr, 32'h3040);
        @(negedge clk);
        check("R12 head held while not ready", pf_addr, 32'h3040);
        check("R12 valid held while not ready", 32'(pf_valid), 32'd1);
        send(32'h3050, 32'h0, 5'b01000, 5'b00000);
        check("R8 no drop at exactly full", 32'(full_drop_count), 32'd0);
        send(32'h3020, 32'h0, 5'b01000, 5'b00000);
        check("R8 one oldest dropped", 32'(full_drop_count), 32'd1);
        drain();
        check("R8 entries kept", 32'(got_n), 32'd4);
        check("R8 new head after drop", got_a[0], 32'h3000);
        check("R8 entry 1", got_a[1], 32'h3000);
        check("R8 entry 2", got_a[2], 32'h2FC0);
        check("R8 newest entry", got_a[3], 32'h2FC0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule